// File: doc/BRIEF.md
# Byte-Wide Register Port for a 24-Bit Counter

This block sits between an 8-bit host bus and a 24-bit counter core. The host uses active-low chip select, read and write strobes, and a control/data select line. The block keeps the counter's mode settings and a preset value, and it latches a copy of the count. A control write carries its register selector in its own top two data bits, so one control address reaches four registers. Data writes fill the preset one byte at a time, and data reads return the latched count one byte at a time. A single byte pointer serves both directions and advances by itself after each access.

The strobes are asynchronous to the system clock. They pass through a synchroniser, and each access takes effect once, on the clock after the synchronised strobe returns high. Writes to the master control register become single-cycle command pulses to the counter core: clear the count, load the preset, and clear the compare toggle. They can also act on local state: reset the pointer, capture the count, or master reset. A status read returns five flag bits that the counter core supplies.

Top module: `cnt_bus_regfile`

## Requirements
- R1: After reset, `preset_q` is 0xFFFFFF, all three mode outputs are zero, the latched count is zero, the byte pointer selects byte 0 and no command pulse is active.
- R2: `bus_oe` is 1 exactly while `bus_cs_n` and `bus_rd_n` are both 0. An access made with `bus_cs_n` high changes no state and raises no pulse.
- R3: A control write (`bus_cd`=1) is steered by data bits 7:6. 00 selects the master command register. 01 loads `in_mode` with bits 5:0. 10 loads `out_mode` with bits 5:0. 11 loads `quad_mode` with bits 1:0. The other mode registers keep their values.
- R4: Data writes (`bus_cd`=0) store into preset byte 0, then byte 1, then byte 2, where byte 0 is `preset_q[7:0]`. The pointer steps after each write and wraps from byte 2 to byte 0.
- R5: During a data read, `bus_dout` shows the latched count byte that the pointer selects. The pointer steps after each read and wraps from byte 2 to byte 0.
- R6: A status read (`bus_cd`=1) returns bit 0 borrow toggle, bit 1 carry toggle, bit 2 compare toggle, bit 3 sign and bit 4 direction, with bits 7:5 zero. It does not move the pointer.
- R7: In a master command write, bit 0 returns the pointer to byte 0 and bit 1 copies `count_in` into the latch.
- R8: In a master command write, bit 2 gives one pulse on `cmd_cnt_clear`, bit 3 one pulse on `cmd_load_cnt` and bit 4 one pulse on `cmd_comp_clear`, each one clock wide. Bits set together all act in the same write, and no zero write is needed between commands.
- R9: In a master command write, bit 5 clears the mode registers, the latch and the pointer, sets the preset to all ones, and pulses `cmd_master_rst`, `cmd_cnt_clear` and `cmd_comp_clear` together. It suppresses the latch capture and the load pulse in the same write.
- R10: An access acts only once the strobe has been released. While the strobe is held low, nothing changes. After release, the effect appears within SYNC_STAGES+2 clocks, and exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_cs_n | input | 1 | Chip select, active low |
| bus_rd_n | input | 1 | Read strobe, active low |
| bus_wr_n | input | 1 | Write strobe, active low |
| bus_cd | input | 1 | 1 = control/status, 0 = preset/latch data |
| bus_din | input | 8 | Write data from host |
| bus_dout | output | 8 | Read data to host |
| bus_oe | output | 1 | Enable for the external data bus driver |
| count_in | input | 24 | Live count value from the counter core |
| st_borrow_tgl | input | 1 | Borrow toggle flag |
| st_carry_tgl | input | 1 | Carry toggle flag |
| st_comp_tgl | input | 1 | Compare toggle flag |
| st_sign | input | 1 | Sign flag |
| st_dir_up | input | 1 | Count direction, 1 = up |
| preset_q | output | 24 | Assembled preset value |
| in_mode | output | 6 | Input mode settings |
| out_mode | output | 6 | Output/count mode settings |
| quad_mode | output | 2 | Quadrature mode selection |
| cmd_cnt_clear | output | 1 | Pulse: clear count, borrow and carry toggles, set sign |
| cmd_load_cnt | output | 1 | Pulse: load count from preset |
| cmd_comp_clear | output | 1 | Pulse: clear compare toggle |
| cmd_master_rst | output | 1 | Pulse: master reset of the counter core |

## Verification
The assertions assume that the host behaves like a well-formed slow bus. Each strobe stays low for several clocks, only one strobe is active at a time, and chip select, control/data select and write data stay steady from before the strobe falls until SYNC_STAGES clocks after it rises. Under these conditions, consecutive command pulses are always separated, and a master reset pulse always coincides with the cleared register state. The bench keeps within these conditions. It changes bus inputs only on falling clock edges. It holds each strobe low for at least four clocks and keeps the other lines steady for six clocks after release, so every access takes effect exactly once.

// File: rtl/cbr_pkg.sv
package cbr_pkg;

    localparam int BUS_W  = 8;
    localparam int MODE_W = 6;
    localparam int QUAD_W = 2;

    // Control register selector carried in data bits 7:6
    typedef enum logic [1:0] {
        SEL_MASTER = 2'b00,
        SEL_INPUT  = 2'b01,
        SEL_OUTPUT = 2'b10,
        SEL_QUAD   = 2'b11
    } ctl_sel_e;

    // Decoded actions of one master command write
    typedef struct packed {
        logic master_rst;
        logic comp_clr;
        logic load_cnt;
        logic cnt_clr;
        logic latch_cap;
        logic ptr_clr;
    } mcr_act_t;

    // Status flags; packing order gives the byte positions
    typedef struct packed {
        logic dir_up;     // bit 4
        logic sign;       // bit 3
        logic comp_tgl;   // bit 2
        logic carry_tgl;  // bit 1
        logic borrow_tgl; // bit 0
    } status_t;

    // Bus fields captured while a strobe is low
    typedef struct packed {
        logic             cs_n;
        logic             cd;
        logic [BUS_W-1:0] data;
    } bus_hold_t;

    // Master reset dominates: it drops capture and load
    function automatic mcr_act_t decode_mcr(input logic [5:0] b);
        mcr_act_t a;
        a.master_rst = b[5];
        a.ptr_clr    = b[0] | b[5];
        a.latch_cap  = b[1] & ~b[5];
        a.cnt_clr    = b[2] | b[5];
        a.load_cnt   = b[3] & ~b[5];
        a.comp_clr   = b[4] | b[5];
        return a;
    endfunction

    function automatic logic [BUS_W-1:0] status_byte(input status_t s);
        return {{(BUS_W-$bits(status_t)){1'b0}}, s};
    endfunction

endpackage

// File: rtl/cbr_strobe_sync.sv
module cbr_strobe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic strb_n,
    output logic active,
    output logic done
);
    logic [STAGES-1:0] sync_q;
    logic              last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '1;
            last_q <= 1'b1;
        end else begin
            sync_q[0] <= strb_n;
            for (int i = 1; i < STAGES; i++) begin
                sync_q[i] <= sync_q[i-1];
            end
            last_q <= sync_q[STAGES-1];
        end
    end

    assign active = ~sync_q[STAGES-1];
    assign done   = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/cbr_ctrl_decode.sv
module cbr_ctrl_decode
    import cbr_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  ctrl_fire,
    input  logic [BUS_W-1:0]      ctrl_data,
    output mcr_act_t              act,
    output logic [MODE_W-1:0]     in_mode,
    output logic [MODE_W-1:0]     out_mode,
    output logic [QUAD_W-1:0]     quad_mode,
    output logic                  cnt_clr_q,
    output logic                  load_cnt_q,
    output logic                  comp_clr_q,
    output logic                  master_rst_q
);
    ctl_sel_e sel;

    always_comb begin
        sel = ctl_sel_e'(ctrl_data[BUS_W-1 -: 2]);
        act = '0;
        if (ctrl_fire && sel == SEL_MASTER) begin
            act = decode_mcr(ctrl_data[5:0]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || act.master_rst) begin
            in_mode   <= '0;
            out_mode  <= '0;
            quad_mode <= '0;
        end else if (ctrl_fire) begin
            case (sel)
                SEL_INPUT:  in_mode   <= ctrl_data[MODE_W-1:0];
                SEL_OUTPUT: out_mode  <= ctrl_data[MODE_W-1:0];
                SEL_QUAD:   quad_mode <= ctrl_data[QUAD_W-1:0];
                default:    ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_clr_q    <= 1'b0;
            load_cnt_q   <= 1'b0;
            comp_clr_q   <= 1'b0;
            master_rst_q <= 1'b0;
        end else begin
            cnt_clr_q    <= act.cnt_clr;
            load_cnt_q   <= act.load_cnt;
            comp_clr_q   <= act.comp_clr;
            master_rst_q <= act.master_rst;
        end
    end
endmodule

// File: rtl/cbr_byte_port.sv
module cbr_byte_port
    import cbr_pkg::*;
#(
    parameter int NUM_BYTES = 3
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       data_wr_fire,
    input  logic                       data_rd_fire,
    input  logic [BUS_W-1:0]           wr_data,
    input  mcr_act_t                   act,
    input  logic [NUM_BYTES*BUS_W-1:0] count_in,
    output logic [NUM_BYTES*BUS_W-1:0] preset_q,
    output logic [BUS_W-1:0]           rd_byte
);
    localparam int PTR_W = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1;
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(NUM_BYTES - 1);

    logic [NUM_BYTES-1:0][BUS_W-1:0] preset_r;
    logic [NUM_BYTES-1:0][BUS_W-1:0] latch_r;
    logic [PTR_W-1:0]                ptr_q;
    logic [PTR_W-1:0]                ptr_nxt;

    assign ptr_nxt = (ptr_q == PTR_LAST) ? '0 : ptr_q + 1'b1;

    always_ff @(posedge clk) begin
        if (rst || act.master_rst) begin
            preset_r <= '1;
            latch_r  <= '0;
            ptr_q    <= '0;
        end else begin
            if (act.latch_cap) begin
                latch_r <= count_in;
            end
            if (act.ptr_clr) begin
                ptr_q <= '0;
            end else if (data_wr_fire) begin
                preset_r[ptr_q] <= wr_data;
                ptr_q           <= ptr_nxt;
            end else if (data_rd_fire) begin
                ptr_q <= ptr_nxt;
            end
        end
    end

    assign preset_q = preset_r;
    assign rd_byte  = latch_r[ptr_q];
endmodule

// File: rtl/cnt_bus_regfile.sv
module cnt_bus_regfile
    import cbr_pkg::*;
#(
    parameter int NUM_BYTES   = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       bus_cs_n,
    input  logic                       bus_rd_n,
    input  logic                       bus_wr_n,
    input  logic                       bus_cd,
    input  logic [7:0]                 bus_din,
    output logic [7:0]                 bus_dout,
    output logic                       bus_oe,
    input  logic [23:0]                count_in,
    input  logic                       st_borrow_tgl,
    input  logic                       st_carry_tgl,
    input  logic                       st_comp_tgl,
    input  logic                       st_sign,
    input  logic                       st_dir_up,
    output logic [23:0]                preset_q,
    output logic [5:0]                 in_mode,
    output logic [5:0]                 out_mode,
    output logic [1:0]                 quad_mode,
    output logic                       cmd_cnt_clear,
    output logic                       cmd_load_cnt,
    output logic                       cmd_comp_clear,
    output logic                       cmd_master_rst
);
    localparam int CNT_W = NUM_BYTES * BUS_W;

    logic      wr_active, wr_done, rd_active, rd_done;
    bus_hold_t wr_hold;
    logic      rd_hold_cs_n, rd_hold_cd;
    logic      ctrl_fire, data_wr_fire, data_rd_fire;
    mcr_act_t  act;
    status_t   st;
    logic [BUS_W-1:0] rd_byte;

    cbr_strobe_sync #(.STAGES(SYNC_STAGES)) u_wr_sync (
        .clk(clk), .rst(rst), .strb_n(bus_wr_n),
        .active(wr_active), .done(wr_done)
    );

    cbr_strobe_sync #(.STAGES(SYNC_STAGES)) u_rd_sync (
        .clk(clk), .rst(rst), .strb_n(bus_rd_n),
        .active(rd_active), .done(rd_done)
    );

    // Capture the qualifying bus fields while each strobe is low
    always_ff @(posedge clk) begin
        if (rst) begin
            wr_hold      <= '{cs_n: 1'b1, cd: 1'b0, data: '0};
            rd_hold_cs_n <= 1'b1;
            rd_hold_cd   <= 1'b0;
        end else begin
            if (wr_active) begin
                wr_hold <= '{cs_n: bus_cs_n, cd: bus_cd, data: bus_din};
            end
            if (rd_active) begin
                rd_hold_cs_n <= bus_cs_n;
                rd_hold_cd   <= bus_cd;
            end
        end
    end

    assign ctrl_fire    = wr_done & ~wr_hold.cs_n &  wr_hold.cd;
    assign data_wr_fire = wr_done & ~wr_hold.cs_n & ~wr_hold.cd;
    assign data_rd_fire = rd_done & ~rd_hold_cs_n & ~rd_hold_cd;

    cbr_ctrl_decode u_decode (
        .clk(clk), .rst(rst),
        .ctrl_fire(ctrl_fire), .ctrl_data(wr_hold.data),
        .act(act),
        .in_mode(in_mode), .out_mode(out_mode), .quad_mode(quad_mode),
        .cnt_clr_q(cmd_cnt_clear), .load_cnt_q(cmd_load_cnt),
        .comp_clr_q(cmd_comp_clear), .master_rst_q(cmd_master_rst)
    );

    cbr_byte_port #(.NUM_BYTES(NUM_BYTES)) u_bytes (
        .clk(clk), .rst(rst),
        .data_wr_fire(data_wr_fire), .data_rd_fire(data_rd_fire),
        .wr_data(wr_hold.data), .act(act),
        .count_in(count_in[CNT_W-1:0]),
        .preset_q(preset_q[CNT_W-1:0]), .rd_byte(rd_byte)
    );

    always_comb begin
        st = '{dir_up: st_dir_up, sign: st_sign, comp_tgl: st_comp_tgl,
               carry_tgl: st_carry_tgl, borrow_tgl: st_borrow_tgl};
        bus_dout = bus_cd ? status_byte(st) : rd_byte;
        bus_oe   = ~bus_cs_n & ~bus_rd_n;
    end
endmodule

// File: rtl/cbr_checker.sv
module cbr_checker #(
    parameter int CNT_W = 24
) (
    input logic             clk,
    input logic             rst,
    input logic             bus_cs_n,
    input logic             bus_oe,
    input logic [CNT_W-1:0] preset_q,
    input logic [5:0]       in_mode,
    input logic [5:0]       out_mode,
    input logic [1:0]       quad_mode,
    input logic             cmd_cnt_clear,
    input logic             cmd_load_cnt,
    input logic             cmd_comp_clear,
    input logic             cmd_master_rst
);
    assert_deselect_no_drive_R2: assert property (@(posedge clk) disable iff (rst)
        bus_cs_n |-> !bus_oe);

    assert_clear_one_cycle_R8: assert property (@(posedge clk) disable iff (rst)
        cmd_cnt_clear |=> !cmd_cnt_clear);

    assert_load_one_cycle_R8: assert property (@(posedge clk) disable iff (rst)
        cmd_load_cnt |=> !cmd_load_cnt);

    assert_comp_one_cycle_R8: assert property (@(posedge clk) disable iff (rst)
        cmd_comp_clear |=> !cmd_comp_clear);

    assert_mrst_state_R9: assert property (@(posedge clk) disable iff (rst)
        cmd_master_rst |-> (preset_q == '1 && in_mode == '0 &&
                            out_mode == '0 && quad_mode == '0));

    assert_mrst_pulses_R9: assert property (@(posedge clk) disable iff (rst)
        cmd_master_rst |-> (cmd_cnt_clear && cmd_comp_clear && !cmd_load_cnt));
endmodule

bind cnt_bus_regfile cbr_checker #(.CNT_W(24)) u_chk (
    .clk(clk), .rst(rst), .bus_cs_n(bus_cs_n), .bus_oe(bus_oe),
    .preset_q(preset_q), .in_mode(in_mode), .out_mode(out_mode),
    .quad_mode(quad_mode), .cmd_cnt_clear(cmd_cnt_clear),
    .cmd_load_cnt(cmd_load_cnt), .cmd_comp_clear(cmd_comp_clear),
    .cmd_master_rst(cmd_master_rst)
);

// File: tb/cnt_bus_regfile_tb_top.sv
module cnt_bus_regfile_tb_top;
    localparam time CLK_PERIOD = 10ns;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bus_cs_n = 1'b1, bus_rd_n = 1'b1, bus_wr_n = 1'b1, bus_cd = 1'b0;
    logic [7:0]  bus_din = '0;
    logic [7:0]  bus_dout;
    logic        bus_oe;
    logic [23:0] count_in = '0;
    logic st_borrow_tgl = 0, st_carry_tgl = 0, st_comp_tgl = 0, st_sign = 0, st_dir_up = 0;
    logic [23:0] preset_q;
    logic [5:0]  in_mode, out_mode;
    logic [1:0]  quad_mode;
    logic cmd_cnt_clear, cmd_load_cnt, cmd_comp_clear, cmd_master_rst;

    int vectors = 0;
    int misses  = 0;
    bit finished = 0;
    logic [3:0] exp_q[$];   // {master, comp_clr, load, cnt_clr}

    always #(CLK_PERIOD/2) clk = ~clk;

    cnt_bus_regfile dut_i (
        .clk(clk), .rst(rst), .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n),
        .bus_wr_n(bus_wr_n), .bus_cd(bus_cd), .bus_din(bus_din),
        .bus_dout(bus_dout), .bus_oe(bus_oe), .count_in(count_in),
        .st_borrow_tgl(st_borrow_tgl), .st_carry_tgl(st_carry_tgl),
        .st_comp_tgl(st_comp_tgl), .st_sign(st_sign), .st_dir_up(st_dir_up),
        .preset_q(preset_q), .in_mode(in_mode), .out_mode(out_mode),
        .quad_mode(quad_mode), .cmd_cnt_clear(cmd_cnt_clear),
        .cmd_load_cnt(cmd_load_cnt), .cmd_comp_clear(cmd_comp_clear),
        .cmd_master_rst(cmd_master_rst)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Expected pulse vector for a master command byte (R8, R9)
    function automatic logic [3:0] mcr_pulses(input logic [7:0] d);
        if (d[5]) return 4'b1101;
        return {1'b0, d[4], d[3], d[2]};
    endfunction

    task automatic bus_write(input logic cs_n_v, input logic cd_v, input logic [7:0] d);
        @(negedge clk);
        bus_cs_n = cs_n_v; bus_cd = cd_v; bus_din = d;
        repeat (2) @(negedge clk);
        bus_wr_n = 1'b0;
        repeat (4) @(negedge clk);
        bus_wr_n = 1'b1;
        repeat (6) @(negedge clk);
        bus_cs_n = 1'b1;
    endtask

    task automatic mcr_write(input logic [7:0] d);
        if (mcr_pulses(d) != 4'b0000) exp_q.push_back(mcr_pulses(d));
        bus_write(1'b0, 1'b1, d);
    endtask

    task automatic bus_read(input logic cd_v, output logic [7:0] d, output logic oe);
        @(negedge clk);
        bus_cs_n = 1'b0; bus_cd = cd_v;
        repeat (2) @(negedge clk);
        bus_rd_n = 1'b0;
        repeat (4) @(negedge clk);
        d = bus_dout; oe = bus_oe;
        bus_rd_n = 1'b1;
        repeat (6) @(negedge clk);
        bus_cs_n = 1'b1;
    endtask

    // Scoreboard monitor for command pulses
    always @(negedge clk) begin
        if (!rst) begin
            logic [3:0] seen;
            seen = {cmd_master_rst, cmd_comp_clear, cmd_load_cnt, cmd_cnt_clear};
            if (seen != 4'b0000) begin
                if (exp_q.size() == 0) check("R8 unexpected pulse", {28'd0, seen}, 32'd0);
                else check("R8/R9 pulse set", {28'd0, seen}, {28'd0, exp_q.pop_front()});
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            misses++;
            $display("FAIL watchdog: actual running expected done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        logic oe;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 preset", preset_q, 32'hFFFFFF);
        check("R1 modes", {in_mode, out_mode, quad_mode}, 0);
        check("R1 pulses", {cmd_master_rst, cmd_comp_clear, cmd_load_cnt, cmd_cnt_clear}, 0);
        check("R2 idle oe", bus_oe, 0);

        // R3 routing
        bus_write(1'b0, 1'b1, 8'b01_101010);
        check("R3 input mode", in_mode, 6'h2A);
        check("R3 others kept", {out_mode, quad_mode}, 0);
        bus_write(1'b0, 1'b1, 8'b10_010101);
        check("R3 output mode", out_mode, 6'h15);
        bus_write(1'b0, 1'b1, 8'b11_000010);
        check("R3 quad mode", quad_mode, 2'b10);
        check("R3 input kept", in_mode, 6'h2A);

        // R4 preset assembly and wrap
        mcr_write(8'h01);
        bus_write(1'b0, 1'b0, 8'h11);
        bus_write(1'b0, 1'b0, 8'h22);
        bus_write(1'b0, 1'b0, 8'h33);
        check("R4 preset bytes", preset_q, 32'h332211);
        bus_write(1'b0, 1'b0, 8'h44);
        check("R4 pointer wrap", preset_q, 32'h332244);

        // R2 deselected write ignored; next selected write still goes to byte 1
        bus_write(1'b1, 1'b0, 8'h99);
        check("R2 deselected write", preset_q, 32'h332244);
        bus_write(1'b1, 1'b1, 8'b01_000001);
        check("R2 deselected ctrl", in_mode, 6'h2A);
        bus_write(1'b0, 1'b0, 8'h55);
        check("R2 pointer unmoved", preset_q, 32'h335544);

        // R7 capture plus pointer reset, R5 byte order and wrap
        count_in = 24'hABCDEF;
        mcr_write(8'h03);
        count_in = 24'h000000;
        bus_read(1'b0, rd, oe);
        check("R5 byte0", rd, 8'hEF);
        check("R2 oe during read", oe, 1);
        bus_read(1'b0, rd, oe);
        check("R5 byte1", rd, 8'hCD);
        bus_read(1'b0, rd, oe);
        check("R7 captured byte2", rd, 8'hAB);
        bus_read(1'b0, rd, oe);
        check("R5 read wrap", rd, 8'hEF);

        // R6 status layout, pointer unmoved
        {st_dir_up, st_sign, st_comp_tgl, st_carry_tgl, st_borrow_tgl} = 5'b10101;
        bus_read(1'b1, rd, oe);
        check("R6 status a", rd, 8'h15);
        {st_dir_up, st_sign, st_comp_tgl, st_carry_tgl, st_borrow_tgl} = 5'b01010;
        bus_read(1'b1, rd, oe);
        check("R6 status b", rd, 8'h0A);
        bus_read(1'b0, rd, oe);
        check("R6 pointer kept", rd, 8'hCD);

        // R8 combined and back-to-back commands
        mcr_write(8'h1C);
        mcr_write(8'h04);
        mcr_write(8'h08);
        mcr_write(8'h10);

        // R10 held strobe takes effect only after release
        @(negedge clk);
        bus_cs_n = 1'b0; bus_cd = 1'b1; bus_din = 8'b01_001111;
        repeat (2) @(negedge clk);
        bus_wr_n = 1'b0;
        repeat (20) @(negedge clk);
        check("R10 held low no effect", in_mode, 6'h2A);
        bus_wr_n = 1'b1;
        repeat (SYNC_WAIT()) @(negedge clk);
        check("R10 effect after release", in_mode, 6'h0F);
        repeat (2) @(negedge clk);
        bus_cs_n = 1'b1;

        // R9 master reset with capture and load also requested
        count_in = 24'h123456;
        mcr_write(8'h2A);
        check("R9 preset ones", preset_q, 32'hFFFFFF);
        check("R9 modes cleared", {in_mode, out_mode, quad_mode}, 0);
        bus_read(1'b0, rd, oe);
        check("R9 latch cleared", rd, 8'h00);

        repeat (4) @(negedge clk);
        check("R8 all pulses seen", exp_q.size(), 0);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    function automatic int SYNC_WAIT();
        return 4;   // SYNC_STAGES + 2 with the default of 2
    endfunction
endmodule